// File: doc/BRIEF.md
# Programmable Ratio Clock Divider

This block derives a slower controller clock from a fast input clock. A 3-bit ratio code picks one of eight division factors. Two of those factors, 6 and 24, are not powers of two, so the block uses a general reload counter instead of tapping counter bits. The result is available in two forms. One is a 50% duty-cycle toggled clock. The other is a one-cycle enable pulse that marks each rising edge of that clock.

Software holds the divider in reset with a dedicated input and programs the ratio code during that time. It reads the latched code and the registered enable back to confirm the write, and then releases the reset. An enable input gates both outputs. A bypass select replaces the divided clock with an external clock input.

Top module: `clk_ratio_div`

## Requirements
- R1: Ratio codes 0,1,2,3,4,5,6,7 select division by 1,2,4,6,8,16,24,32. For every ratio N of 2 or more, `div_clk_o` holds each level for exactly N/2 input cycles, which gives a 50% duty cycle.
- R2: While `div_rst_i` is high, the counter is preloaded and `div_clk_o` and `div_pulse_o` are low from the next cycle on. This applies to the divided path; the bypass path is not affected.
- R3: `sel_rb_o` takes the value of `sel_i` on every clock edge at which `div_rst_i` is high. At all other times it holds, and changes to `sel_i` have no effect on the division.
- R4: After `div_rst_i` falls, `div_clk_o` first goes high on the (N/2)-th rising edge of `clk_i`. It is still low after edge N/2-1.
- R5: With ratio code 0, `div_clk_o` follows `clk_i`, gated by the enable, and is low while `div_rst_i` is high.
- R6: `en_rb_o` is `clk_en_i` registered on each edge. While `en_rb_o` is low, both outputs are low. The counter keeps running, so the phase is kept when the enable returns.
- R7: With `byp_sel_i` equal to 1, `div_clk_o` follows `ext_clk_i`, gated by the enable. With 0, it carries the divided clock.
- R8: `div_pulse_o` is high for one cycle on the edge where `div_clk_o` rises, which is once every N cycles. With ratio code 0 it stays high while the block is running.
- R9: While `rst_ni` is low, every register is cleared: both outputs are low, and `sel_rb_o` and `en_rb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_rst_i | input | 1 | Divider hold and programming window, active high |
| sel_i | input | 3 | Ratio code |
| clk_en_i | input | 1 | Output enable |
| byp_sel_i | input | 1 | 1 selects the external clock |
| ext_clk_i | input | 1 | External clock for bypass |
| div_clk_o | output | 1 | Divided, bypassed or gated clock |
| div_pulse_o | output | 1 | One-cycle pulse at each divided rising edge |
| sel_rb_o | output | 3 | Latched ratio code readback |
| en_rb_o | output | 1 | Registered enable readback |

## Verification
The hardest cases to reach from the ports are a ratio code change while the divider runs, and an enable drop in the middle of a period. In both, the internal counter must be unaffected even though nothing at the outputs shows it directly. The stimulus changes `sel_i` to a different ratio several half-periods after release and keeps it there. The expected waveform still follows the old ratio and the readback stays fixed. The enable is also dropped for a stretch that is not a multiple of the half-period. When it returns, the scoreboard expects the output phase that continuous counting from release would give.

// File: rtl/crd_pkg.sv
package crd_pkg;
   localparam int CRD_SEL_W     = 3;
   localparam int CRD_MAX_RATIO = 32;

   typedef logic [CRD_SEL_W-1:0] crd_sel_t;

   // Ratio code to division factor; order is behaviour (code value = index).
   function automatic int crd_ratio(crd_sel_t code);
      int r;
      case (code)
         3'd0:    r = 1;
         3'd1:    r = 2;
         3'd2:    r = 4;
         3'd3:    r = 6;
         3'd4:    r = 8;
         3'd5:    r = 16;
         3'd6:    r = 24;
         default: r = 32;
      endcase
      return r;
   endfunction

   // Reload value: half-period minus one (zero for the unity ratio).
   function automatic int crd_half_m1(crd_sel_t code);
      int r;
      r = crd_ratio(code);
      return (r < 2) ? 0 : (r / 2) - 1;
   endfunction
endpackage

// File: rtl/crd_cfg_latch.sv
module crd_cfg_latch
   import crd_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     hold_i,
   input  crd_sel_t sel_i,
   input  logic     en_i,
   output crd_sel_t sel_q_o,
   output logic     en_q_o
);
   crd_sel_t sel_q;
   logic     en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else begin
         en_q <= en_i;
         if (hold_i) sel_q <= sel_i;
      end
   end

   assign sel_q_o = sel_q;
   assign en_q_o  = en_q;
endmodule

// File: rtl/crd_counter.sv
module crd_counter
   import crd_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     hold_i,
   input  crd_sel_t load_sel_i,
   output logic     tog_o,
   output logic     pulse_o,
   output logic     unity_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic             tog_q;
   logic             pulse_q;
   logic             unity_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         reload_q <= '0;
         tog_q    <= 1'b0;
         pulse_q  <= 1'b0;
         unity_q  <= 1'b0;
      end else if (hold_i) begin
         reload_q <= CNT_W'(crd_half_m1(load_sel_i));
         cnt_q    <= CNT_W'(crd_half_m1(load_sel_i));
         unity_q  <= (crd_ratio(load_sel_i) == 1);
         tog_q    <= 1'b0;
         pulse_q  <= 1'b0;
      end else if (unity_q) begin
         pulse_q <= 1'b1;
      end else begin
         pulse_q <= at_zero && !tog_q;
         if (at_zero) begin
            cnt_q <= reload_q;
            tog_q <= ~tog_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign tog_o   = tog_q;
   assign pulse_o = pulse_q;
   assign unity_o = unity_q;
endmodule

// File: rtl/crd_outsel.sv
module crd_outsel (
   input  logic clk_i,
   input  logic hold_i,
   input  logic tog_i,
   input  logic unity_i,
   input  logic pulse_i,
   input  logic en_i,
   input  logic byp_i,
   input  logic ext_clk_i,
   output logic div_clk_o,
   output logic div_pulse_o
);
   logic div_src;

   always_comb begin
      div_src     = unity_i ? (clk_i & ~hold_i) : tog_i;
      div_clk_o   = en_i & (byp_i ? ext_clk_i : div_src);
      div_pulse_o = en_i & pulse_i;
   end
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
   import crd_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 div_rst_i,
   input  logic [CRD_SEL_W-1:0] sel_i,
   input  logic                 clk_en_i,
   input  logic                 byp_sel_i,
   input  logic                 ext_clk_i,
   output logic                 div_clk_o,
   output logic                 div_pulse_o,
   output logic [CRD_SEL_W-1:0] sel_rb_o,
   output logic                 en_rb_o
);
   localparam int NEED_W = $clog2(CRD_MAX_RATIO / 2);

   generate
      if (CNT_W < NEED_W) begin : g_width_check
         $error("CNT_W too narrow for the largest half-period");
      end
   endgenerate

   logic tog, pulse, unity, en_q;

   crd_cfg_latch u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (div_rst_i),
      .sel_i  (sel_i),
      .en_i   (clk_en_i),
      .sel_q_o(sel_rb_o),
      .en_q_o (en_q)
   );

   crd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_i    (div_rst_i),
      .load_sel_i(sel_i),
      .tog_o     (tog),
      .pulse_o   (pulse),
      .unity_o   (unity)
   );

   crd_outsel u_out (
      .clk_i      (clk_i),
      .hold_i     (div_rst_i),
      .tog_i      (tog),
      .unity_i    (unity),
      .pulse_i    (pulse),
      .en_i       (en_q),
      .byp_i      (byp_sel_i),
      .ext_clk_i  (ext_clk_i),
      .div_clk_o  (div_clk_o),
      .div_pulse_o(div_pulse_o)
   );

   assign en_rb_o = en_q;
endmodule

// File: rtl/crd_checker.sv
module crd_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       div_rst_i,
   input logic [2:0] sel_i,
   input logic       clk_en_i,
   input logic       div_pulse_o,
   input logic [2:0] sel_rb_o,
   input logic       en_rb_o
);
   assert_sel_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_rst_i |=> (sel_rb_o == $past(sel_i)));

   assert_sel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !div_rst_i |=> $stable(sel_rb_o));

   assert_hold_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_rst_i |=> !div_pulse_o);

   assert_en_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_en_i |=> (!div_pulse_o && !en_rb_o));

   assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_pulse_o && sel_rb_o != 3'd0 && !div_rst_i) |=> !div_pulse_o);
endmodule

bind clk_ratio_div crd_checker u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .div_rst_i  (div_rst_i),
   .sel_i      (sel_i),
   .clk_en_i   (clk_en_i),
   .div_pulse_o(div_pulse_o),
   .sel_rb_o   (sel_rb_o),
   .en_rb_o    (en_rb_o)
);

// File: tb/clk_ratio_div_tb.sv
module clk_ratio_div_tb;
   logic       clk = 1'b0;
   logic       rst_n, div_rst, en, byp, ext;
   logic [2:0] sel;
   logic       div_clk, div_pulse, en_rb;
   logic [2:0] sel_rb;

   always #10 clk = ~clk;

   clk_ratio_div u_dut (
      .clk_i(clk), .rst_ni(rst_n), .div_rst_i(div_rst), .sel_i(sel),
      .clk_en_i(en), .byp_sel_i(byp), .ext_clk_i(ext),
      .div_clk_o(div_clk), .div_pulse_o(div_pulse),
      .sel_rb_o(sel_rb), .en_rb_o(en_rb)
   );

   typedef struct {
      string      tag_clk;
      logic       e_clk;
      logic       e_pulse;
      logic [2:0] e_sel;
      logic       e_en;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad   = 0;
   int m_k   = 0;
   logic [2:0] m_sel = 3'd0;
   int ratios[8] = '{1, 2, 4, 6, 8, 16, 24, 32};

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic step(logic rs, logic e, logic b, logic x, logic [2:0] s, string tag);
      item_t it;
      int n, h;
      logic dv, pl;
      @(negedge clk);
      div_rst = rs; en = e; byp = b; ext = x; sel = s;
      if (rs) begin m_sel = s; m_k = 0; end
      else m_k++;
      n = ratios[m_sel];
      h = (n < 2) ? 1 : n / 2;
      if (rs) begin dv = 1'b0; pl = 1'b0; end
      else if (n == 1) begin dv = 1'b1; pl = 1'b1; end
      else begin
         dv = ((m_k / h) % 2) == 1;
         pl = ((m_k % h) == 0) && (((m_k / h) % 2) == 1);
      end
      it.tag_clk = tag;
      if (!rs && n > 1 && !b && (m_k == h || m_k == h - 1)) it.tag_clk = "R4";
      it.e_clk   = e & (b ? x : dv);
      it.e_pulse = e & pl;
      it.e_sel   = m_sel;
      it.e_en    = e;
      q.push_back(it);
   endtask

   // Monitor: samples in the high phase, after the registers have settled.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            chk(it.tag_clk, int'(div_clk), int'(it.e_clk));
            chk("R8", int'(div_pulse), int'(it.e_pulse));
            chk("R3", int'(sel_rb), int'(it.e_sel));
            chk("R6", int'(en_rb), int'(it.e_en));
         end
      end
   end

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; div_rst = 1'b1; en = 1'b1; byp = 1'b0; ext = 1'b0; sel = 3'd5;
      repeat (3) @(negedge clk);
      @(posedge clk); #5;
      chk("R9", int'(div_clk), 0);
      chk("R9", int'(div_pulse), 0);
      chk("R9", int'(sel_rb), 0);
      chk("R9", int'(en_rb), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Every ratio code from release (R1, R4, R5, R8)
      for (int c = 0; c < 8; c++) begin
         repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0, 3'(c), "R2");
         for (int i = 0; i < 2 * ratios[c] + 3; i++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 3'(c), (c == 0) ? "R5" : "R1");
      end

      // Code change while running is ignored (R3)
      repeat (2) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R2");
      repeat (5) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd3, "R3");
      repeat (15) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd7, "R3");

      // Enable drop keeps phase (R6)
      repeat (2) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd4, "R2");
      repeat (6) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, "R6");
      repeat (7) step(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, "R6");
      repeat (10) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, "R6");

      // Bypass follows the external clock (R7)
      repeat (2) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd2, "R2");
      for (int i = 0; i < 12; i++)
         step(1'b0, 1'b1, 1'b1, (i % 3) == 0, 3'd2, "R7");
      step(1'b0, 1'b0, 1'b1, 1'b1, 3'd2, "R7");
      step(1'b0, 1'b1, 1'b0, 1'b1, 3'd2, "R7");

      // Divider reset in mid-run, then reprogram (R2)
      repeat (2) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd5, "R2");
      repeat (10) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd5, "R1");
      repeat (4) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd1, "R2");
      repeat (6) step(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, "R1");

      repeat (3) @(posedge clk);
      #7;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule